// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This core runs a program held in one word-addressed memory. It has a single accumulator. Each instruction passes through a fetch phase, a decode step and an execute phase. Every transfer between the core and memory goes through a memory address register and a memory data register, and each transfer takes its own clock step. A sequencer issues one micro-operation per cycle. The datapath holds these registers:

- program counter
- instruction register
- address register
- data register
- accumulator
- adder

The memory behind the core is synchronous and has one cycle of read latency. When the core raises the read strobe, the memory registers the addressed word. The word is available in the cycle after the strobe, and the data register captures it at the end of that cycle. A write is a single-cycle strobe that carries the data register contents. The core supports load, add, store and halt. Any other opcode is skipped.

Top module: `acc_cpu_core`

## Requirements
- R1: The active-low asynchronous reset clears the program counter, instruction, address, data and accumulator registers, and it drops both strobes and `halted_o` at once. After reset is released, the first memory access is a read of address 0.
- R2: Each fetch issues one read strobe at the program counter address, and the program counter then advances by one. Successive instructions are fetched from consecutive addresses.
- R3: An instruction word carries the opcode in bits 15:12 and an address operand in bits 11:0. The opcodes are load = 4'h1, add = 4'h2, store = 4'h3 and halt = 4'hF.
- R4: A load reads the word at its operand address and replaces the accumulator with that word.
- R5: An add reads the word at its operand address and writes the accumulator plus that word, modulo 2^16, back to the accumulator.
- R6: A store drives the accumulator value on `mem_wdata_o` at its operand address, with a write strobe that lasts exactly one cycle.
- R7: The accumulator keeps its value across instructions. Loading 2 and later adding a word that holds 3 leaves 5.
- R8: Every other opcode (for example 4'h0, 4'h5 and 4'hE) makes no data access and leaves the accumulator unchanged. Fetch then continues at the next address.
- R9: Halt raises `halted_o`. From then on, neither strobe is asserted until reset.
- R10: The read and write strobes are never asserted together, and each strobe lasts a single cycle.
- R11: Counted from reset release, load and add take 9 cycles, store takes 8, a skipped opcode takes 6, and halt raises `halted_o` 6 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory address (address register) |
| mem_rd_o | output | 1 | Read strobe; data is expected in the following cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 16 | Write data (data register) |
| mem_rdata_i | input | 16 | Read data from memory |
| halted_o | output | 1 | Core has executed halt |

## Verification
A load/add/store/halt program is run over a table of operand pairs: small values, zeros, a sum that wraps, two half-range values that cancel, and a sum that crosses into the sign bit. Together these separate a correct 16-bit modulo adder from a truncated or pass-through one. Directed programs then cover the following:

- An accumulator carried across a skipped opcode.
- A load that overwrites an earlier load.
- Several unused opcodes, where the logged read order and the cycle count show whether any spurious data access occurred.
- A halt followed by code that must never run.
- A reset asserted in the middle of a run.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    S_F_MAR, S_F_RD, S_F_MDR, S_F_IR, S_F_PC,
    S_DEC,
    S_E_RD, S_E_MDR, S_E_ACC,
    S_E_SMDR, S_E_WR,
    S_HALT
  } step_e;

  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_ADD   = 4'h2;
  localparam logic [3:0] OPC_STORE = 4'h3;
  localparam logic [3:0] OPC_HALT  = 4'hF;

  // one-hot-ish micro-op enables, one step per cycle
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_opd;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic ir_load;
    logic pc_inc;
    logic acc_load;
    logic acc_add;
    logic rd;
    logic wr;
    logic halted;
  } uop_t;

endpackage

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  logic         add_i,
  output logic [W-1:0] res_o
);
  always_comb res_o = add_i ? (acc_i + opd_i) : opd_i;
endmodule

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output uop_t             uop_o
);
  step_e step_q, step_d;
  logic  is_ld, is_add, is_st, is_hlt;

  always_comb begin
    is_ld  = (opcode_i == OPC_W'(OPC_LOAD));
    is_add = (opcode_i == OPC_W'(OPC_ADD));
    is_st  = (opcode_i == OPC_W'(OPC_STORE));
    is_hlt = (opcode_i == OPC_W'(OPC_HALT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= S_F_MAR;
    else         step_q <= step_d;
  end

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      S_F_MAR:  step_d = S_F_RD;
      S_F_RD:   step_d = S_F_MDR;
      S_F_MDR:  step_d = S_F_IR;
      S_F_IR:   step_d = S_F_PC;
      S_F_PC:   step_d = S_DEC;
      S_DEC: begin
        if (is_ld || is_add) step_d = S_E_RD;
        else if (is_st)      step_d = S_E_SMDR;
        else if (is_hlt)     step_d = S_HALT;
        else                 step_d = S_F_MAR;
      end
      S_E_RD:   step_d = S_E_MDR;
      S_E_MDR:  step_d = S_E_ACC;
      S_E_ACC:  step_d = S_F_MAR;
      S_E_SMDR: step_d = S_E_WR;
      S_E_WR:   step_d = S_F_MAR;
      S_HALT:   step_d = S_HALT;
      default:  step_d = S_F_MAR;
    endcase
  end

  always_comb begin
    uop_o = '0;
    unique case (step_q)
      S_F_MAR:  uop_o.mar_from_pc  = 1'b1;
      S_F_RD:   uop_o.rd           = 1'b1;
      S_F_MDR:  uop_o.mdr_from_mem = 1'b1;
      S_F_IR:   uop_o.ir_load      = 1'b1;
      S_F_PC:   uop_o.pc_inc       = 1'b1;
      S_DEC:    uop_o.mar_from_opd = is_ld | is_add | is_st;
      S_E_RD:   uop_o.rd           = 1'b1;
      S_E_MDR:  uop_o.mdr_from_mem = 1'b1;
      S_E_ACC: begin
        uop_o.acc_load = 1'b1;
        uop_o.acc_add  = is_add;
      end
      S_E_SMDR: uop_o.mdr_from_acc = 1'b1;
      S_E_WR:   uop_o.wr           = 1'b1;
      S_HALT:   uop_o.halted       = 1'b1;
      default:  uop_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_dp.sv
`timescale 1ns/1ps
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  uop_t              uop_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, mdr_q, acc_q, alu_res;

  acc_cpu_alu #(.W(DATA_W)) i_alu (
    .acc_i (acc_q),
    .opd_i (mdr_q),
    .add_i (uop_i.acc_add),
    .res_o (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      acc_q <= '0;
    end else begin
      if (uop_i.mar_from_pc)       mar_q <= pc_q;
      else if (uop_i.mar_from_opd) mar_q <= ir_q[ADDR_W-1:0];
      if (uop_i.mdr_from_mem)      mdr_q <= rdata_i;
      else if (uop_i.mdr_from_acc) mdr_q <= acc_q;
      if (uop_i.ir_load)           ir_q  <= mdr_q;
      if (uop_i.pc_inc)            pc_q  <= pc_q + 1'b1;
      if (uop_i.acc_load)          acc_q <= alu_res;
    end
  end

  assign opcode_o = ir_q[DATA_W-1 -: OPC_W];
  assign mar_o    = mar_q;
  assign mdr_o    = mdr_q;
  assign pc_o     = pc_q;
endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);
  uop_t              uop;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] pc_q;

  acc_cpu_seq #(.OPC_W(OPC_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .uop_o    (uop)
  );

  acc_cpu_dp #(.DATA_W(DATA_W), .OPC_W(OPC_W)) i_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .uop_i    (uop),
    .rdata_i  (mem_rdata_i),
    .opcode_o (opcode),
    .mar_o    (mem_addr_o),
    .mdr_o    (mem_wdata_o),
    .pc_o     (pc_q)
  );

  assign mem_rd_o = uop.rd;
  assign mem_wr_o = uop.wr;
  assign halted_o = uop.halted;
endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rd_i,
  input logic              mem_wr_i,
  input logic              halted_i,
  input logic [ADDR_W-1:0] pc_i
);
  // R10
  no_rw_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_i && mem_wr_i));
  // R10
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |=> !mem_rd_i);
  // R6
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |=> !mem_wr_i);
  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);
  // R9
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !(mem_rd_i || mem_wr_i));
  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_i != $past(pc_i)) |-> (pc_i == ADDR_W'($past(pc_i) + 1'b1)));
endmodule

bind acc_cpu_core acc_cpu_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_rd_i (mem_rd_o),
  .mem_wr_i (mem_wr_o),
  .halted_i (halted_o),
  .pc_i     (pc_q)
);

// File: tb/test_acc_cpu_core.sv
`timescale 1ns/1ps
module test_acc_cpu_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o, halted_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;

  int n_chk = 0, n_bad = 0;
  int cyc_total = 0;

  always #2.5 clk_i = ~clk_i;

  acc_cpu_core i_acc_cpu_core (
    .clk_i, .rst_ni, .mem_addr_o, .mem_rd_o, .mem_wr_o,
    .mem_wdata_o, .mem_rdata_i, .halted_o
  );

  // memory model: one-cycle read latency
  logic [15:0] mem [256];
  always @(posedge clk_i) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
  end

  // bus monitor
  logic [11:0] rd_log [32];
  int          rd_cnt, wr_cnt, both_cnt, quiet_bad;
  logic [11:0] wr_addr;
  logic [15:0] wr_data;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_rd_o && rd_cnt < 32) rd_log[rd_cnt] = mem_addr_o;
      if (mem_rd_o) rd_cnt++;
      if (mem_wr_o) begin wr_cnt++; wr_addr = mem_addr_o; wr_data = mem_wdata_o; end
      if (mem_rd_o && mem_wr_o) both_cnt++;
      if (halted_o && (mem_rd_o || mem_wr_o)) quiet_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  endtask

  // hold reset, clear logs, release and count cycles to halt
  task automatic run(output int cycles);
    rst_ni = 1'b0;
    rd_cnt = 0; wr_cnt = 0; both_cnt = 0; quiet_bad = 0;
    wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    cycles = 0;
    while (!halted_o && cycles < 500) begin
      @(negedge clk_i);
      cycles++;
    end
  endtask

  // a, b, expected sum
  localparam logic [15:0] VEC [6][3] = '{
    '{16'h0002, 16'h0003, 16'h0005},
    '{16'h0000, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'h0002, 16'h0001},
    '{16'h8000, 16'h8000, 16'h0000},
    '{16'h1234, 16'h4321, 16'h5555},
    '{16'h7FFF, 16'h0001, 16'h8000}
  };

  initial begin : watchdog
    while (cyc_total < 150000) begin
      @(posedge clk_i);
      cyc_total++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int cyc;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(mem_rd_o == 0 && mem_wr_o == 0, "R1 strobes in reset", {mem_rd_o, mem_wr_o}, 0);
    chk(halted_o == 0, "R1 halted in reset", halted_o, 0);
    chk(mem_addr_o == 0, "R1 addr in reset", mem_addr_o, 0);

    // table: LOAD 40; ADD 41; STORE 42; HALT  (R3 encodings)
    for (int v = 0; v < 6; v++) begin
      clear_mem();
      mem[0] = 16'h1040; mem[1] = 16'h2041; mem[2] = 16'h3042; mem[3] = 16'hF000;
      mem[8'h40] = VEC[v][0]; mem[8'h41] = VEC[v][1]; mem[8'h42] = 16'hDEAD;
      run(cyc);
      chk(mem[8'h42] == VEC[v][2], "R5 sum stored", mem[8'h42], VEC[v][2]);
      chk(wr_data == VEC[v][2], "R6 write data", wr_data, VEC[v][2]);
      chk(wr_cnt == 1 && wr_addr == 12'h042, "R6 write addr", wr_addr, 12'h042);
      chk(cyc == 32, "R11 cycles to halt", cyc, 32);
      chk(rd_cnt == 6, "R2 read count", rd_cnt, 6);
      chk(rd_log[0] == 0 && rd_log[1] == 12'h040 && rd_log[2] == 1 &&
          rd_log[3] == 12'h041 && rd_log[4] == 2 && rd_log[5] == 3,
          "R2 R4 read order", {rd_log[1], rd_log[3]}, {12'h040, 12'h041});
      chk(both_cnt == 0, "R10 rd/wr overlap", both_cnt, 0);
    end

    // R7 R8: LOAD 50; op 5 (skip); ADD 51; STORE 52; HALT
    clear_mem();
    mem[0] = 16'h1050; mem[1] = 16'h5000; mem[2] = 16'h2051; mem[3] = 16'h3052; mem[4] = 16'hF000;
    mem[8'h50] = 16'd2; mem[8'h51] = 16'd3;
    run(cyc);
    chk(mem[8'h52] == 16'd5, "R7 accumulator carried", mem[8'h52], 5);
    chk(cyc == 38, "R8 R11 skip takes 6 cycles", cyc, 38);
    chk(rd_cnt == 7 && rd_log[2] == 1 && rd_log[3] == 2,
        "R8 no data access on skip", rd_log[3], 2);

    // R8 opcodes 0 and E skipped, accumulator unchanged
    clear_mem();
    mem[0] = 16'h1060; mem[1] = 16'h0061; mem[2] = 16'hE061; mem[3] = 16'h3062; mem[4] = 16'hF000;
    mem[8'h60] = 16'hA5A5; mem[8'h61] = 16'h1111;
    run(cyc);
    chk(mem[8'h62] == 16'hA5A5, "R8 acc unchanged", mem[8'h62], 16'hA5A5);
    chk(rd_cnt == 6, "R8 no extra reads", rd_cnt, 6);

    // R4 load overwrites
    clear_mem();
    mem[0] = 16'h1070; mem[1] = 16'h1071; mem[2] = 16'h3072; mem[3] = 16'hF000;
    mem[8'h70] = 16'h0F0F; mem[8'h71] = 16'h3C3C;
    run(cyc);
    chk(mem[8'h72] == 16'h3C3C, "R4 load replaces acc", mem[8'h72], 16'h3C3C);

    // R9 halt stops, later code never runs
    clear_mem();
    mem[0] = 16'hF000; mem[1] = 16'h3080; mem[8'h80] = 16'h7777;
    run(cyc);
    chk(cyc == 6, "R9 R11 halt timing", cyc, 6);
    repeat (30) @(negedge clk_i);
    chk(halted_o == 1, "R9 halted holds", halted_o, 1);
    chk(quiet_bad == 0 && rd_cnt == 1 && wr_cnt == 0, "R9 no strobes after halt", rd_cnt, 1);
    chk(mem[8'h80] == 16'h7777, "R9 store after halt not run", mem[8'h80], 16'h7777);

    // R1 asynchronous reset mid-run, restart from address 0
    clear_mem();
    mem[0] = 16'h1090; mem[1] = 16'h3091; mem[2] = 16'hF000; mem[8'h90] = 16'h4242;
    run(cyc);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    chk(mem_addr_o == 0 && mem_rd_o == 0 && halted_o == 0, "R1 async clear",
        {mem_addr_o, mem_rd_o, halted_o}, 0);
    rd_cnt = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(rd_cnt == 1 && rd_log[0] == 0, "R1 first fetch at 0", rd_log[0], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule